// File: doc/BRIEF.md
# Lock-Assist Boost Window Detector

This block drives a three-state boost output that helps a phase-locked loop charge its loop filter quickly at start-up. While boosting is armed, each phase-correction pulse from the phase detector is copied to the boost output: an up correction drives the output high, a down correction drives it low, and no correction leaves the output floating. The output is given as a drive-enable plus a drive level, so the pad cell can build the three-state buffer.

The block also watches the divided feedback signal. Each falling edge of the feedback opens a window of 62 fast-clock samples, centred on that edge. The correction pulses are delayed by 31 cycles inside the block, so the half of the window that lies before the edge can be checked without knowing the divider count ahead of time. The first correction pulse that lies wholly inside a window stops boosting. Once stopped, boosting stays off until the operate enable has been low and then high again. New divider settings and a later loss of lock do not arm it again. While the operate enable is low the output floats, and the correction history and the window are cleared.

Top module: `lock_boost_window`

## Requirements
- R1: After reset, and from the first cycle after the operate enable is sampled low, boostEn is 0 (the output floats). While the enable is low, the correction history and the window are cleared.
- R2: While boosting is armed, a cycle in which upIn was sampled high 31 clock edges earlier gives boostEn=1 and boostLvl=1.
- R3: While boosting is armed, a cycle in which dnIn (and not upIn) was sampled high 31 clock edges earlier gives boostEn=1 and boostLvl=0. When both are high, up wins.
- R4: A feedback falling edge at sample f (fvIn high at f-1, low at f, both sampled while operate is high) opens a window that covers the correction samples f-31 to f+30 inclusive (62 samples).
- R5: A correction pulse (a run of samples with upIn or dnIn high) whose every sample lies inside a window stops boosting. From the cycle after the delayed pulse ends, boostEn is 0.
- R6: A correction pulse that starts before the window, or that still runs after the window closes, does not stop boosting.
- R7: Once boosting has stopped, boostEn stays 0 for as long as operate stays high, whatever later pulses and feedback edges arrive.
- R8: A low-then-high sequence on operate arms boosting again, and delayed corrections drive the output once more.
- R9: While boosting is armed, a cycle with no delayed correction active gives boostEn=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock (the oscillator being divided) |
| rstN | input | 1 | Asynchronous active-low reset |
| operate | input | 1 | Operate enable: high runs the block, low is standby |
| fvIn | input | 1 | Divided feedback signal; its falling edge centres the window |
| upIn | input | 1 | Up-correction pulse from the phase detector |
| dnIn | input | 1 | Down-correction pulse from the phase detector |
| boostEn | output | 1 | Boost output drive enable (0 means the output floats) |
| boostLvl | output | 1 | Boost output drive level, valid while boostEn is 1 |

## Verification
The hardest situation to reach from the ports is a correction pulse that sits exactly on a window edge. The pulse has to be placed at a sample offset relative to a feedback fall that the delay line hides, and boosting must still be armed when it arrives. Directed cases place pulses one sample outside and exactly on both window bounds. One pulse fills the whole 62-sample window. Further directed cases show that boosting stays off after a stop and comes back after standby. Random blocks then mix pulses of random length and direction with random feedback falls. Each block starts with a short standby, so boosting is armed again many times and many fit and no-fit decisions are made.

// File: rtl/lbw_pkg.sv
package lbw_pkg;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic clr;          // standby: wipe history and window
  } lbwStrobe_t;

  // Status from the datapath to the control.
  typedef struct packed {
    logic corrActive;   // delayed correction present
    logic corrUp;       // delayed correction is an up correction
    logic winActive;    // window open for the current delayed sample
    logic fitEvt;       // a pulse just ended and lay wholly in a window
  } lbwStatus_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BOOST = 2'd1,
    ST_DONE  = 2'd2
  } lbwState_t;

endpackage

// File: rtl/lbw_delay.sv
module lbw_delay #(
  parameter int DEPTH = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    pipe <= '0;
    else if (clr) pipe <= '0;
    else          pipe <= {pipe[DEPTH-2:0], din};
  end

  assign dout = pipe[DEPTH-1];
endmodule

// File: rtl/lbw_datapath.sv
module lbw_datapath
  import lbw_pkg::*;
#(
  parameter int HALF_WIN = 31
) (
  input  logic       clk,
  input  logic       rstN,
  input  lbwStrobe_t strobe,
  input  logic       fvIn,
  input  logic       upIn,
  input  logic       dnIn,
  output lbwStatus_t stat
);
  localparam int WIN_LEN = 2 * HALF_WIN;
  localparam int DLY     = HALF_WIN + 1;
  localparam int CW      = $clog2(WIN_LEN + 1);
  localparam logic [CW-1:0] WIN_INIT = CW'(WIN_LEN);

  // lane 0 carries up corrections, lane 1 carries down corrections
  logic [1:0] laneIn;
  logic [1:0] laneOut;
  assign laneIn = {dnIn, upIn};

  for (genvar gi = 0; gi < 2; gi++) begin : g_lane
    lbw_delay #(.DEPTH(DLY)) uDly (
      .clk  (clk),
      .rstN (rstN),
      .clr  (strobe.clr),
      .din  (laneIn[gi]),
      .dout (laneOut[gi])
    );
  end

  // window generator: opened by the raw feedback fall, which lines up
  // with the correction sample HALF_WIN before that edge
  logic          fvPrev;
  logic [CW-1:0] winCnt;
  logic          fvFall;
  assign fvFall = fvPrev & ~fvIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fvPrev <= 1'b0;
      winCnt <= '0;
    end else if (strobe.clr) begin
      fvPrev <= 1'b0;
      winCnt <= '0;
    end else begin
      fvPrev <= fvIn;
      if (fvFall)              winCnt <= WIN_INIT;
      else if (winCnt != '0)   winCnt <= winCnt - 1'b1;
    end
  end

  // pulse tracker: a pulse fits when every one of its samples saw the window
  logic corrNow;
  logic corrPrev;
  logic fitOk;
  logic winNow;
  assign corrNow = |laneOut;
  assign winNow  = (winCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      corrPrev <= 1'b0;
      fitOk    <= 1'b0;
    end else if (strobe.clr) begin
      corrPrev <= 1'b0;
      fitOk    <= 1'b0;
    end else begin
      corrPrev <= corrNow;
      if (corrNow && !corrPrev) fitOk <= winNow;
      else if (corrNow)         fitOk <= fitOk & winNow;
    end
  end

  always_comb begin
    stat.corrActive = corrNow;
    stat.corrUp     = laneOut[0];
    stat.winActive  = winNow;
    stat.fitEvt     = ~corrNow & corrPrev & fitOk;
  end
endmodule

// File: rtl/lbw_control.sv
module lbw_control
  import lbw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       operate,
  input  lbwStatus_t stat,
  output lbwStrobe_t strobe,
  output logic       boostEn,
  output logic       boostLvl
);
  lbwState_t stQ;
  lbwState_t stD;

  always_comb begin
    stD = stQ;
    if (!operate) begin
      stD = ST_IDLE;
    end else begin
      unique case (stQ)
        ST_IDLE:  stD = ST_BOOST;
        ST_BOOST: if (stat.fitEvt) stD = ST_DONE;
        ST_DONE:  stD = ST_DONE;
        default:  stD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stQ <= ST_IDLE;
    else       stQ <= stD;
  end

  assign strobe.clr = ~operate;
  assign boostEn    = (stQ == ST_BOOST) & stat.corrActive;
  assign boostLvl   = boostEn & stat.corrUp;
endmodule

// File: rtl/lock_boost_window.sv
module lock_boost_window
  import lbw_pkg::*;
#(
  parameter int HALF_WIN = 31
) (
  input  logic clk,
  input  logic rstN,
  input  logic operate,
  input  logic fvIn,
  input  logic upIn,
  input  logic dnIn,
  output logic boostEn,
  output logic boostLvl
);
  lbwStrobe_t ctlStrobe;
  lbwStatus_t dpStat;

  lbw_datapath #(.HALF_WIN(HALF_WIN)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (ctlStrobe),
    .fvIn   (fvIn),
    .upIn   (upIn),
    .dnIn   (dnIn),
    .stat   (dpStat)
  );

  lbw_control uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .operate  (operate),
    .stat     (dpStat),
    .strobe   (ctlStrobe),
    .boostEn  (boostEn),
    .boostLvl (boostLvl)
  );
endmodule

// File: rtl/lbw_checker.sv
module lbw_checker
  import lbw_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       operate,
  input logic       fvIn,
  input logic       boostEn,
  input logic       boostLvl,
  input lbwStatus_t stat
);
  logic stopSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         stopSeen <= 1'b0;
    else if (!operate) stopSeen <= 1'b0;
    else if (stat.fitEvt) stopSeen <= 1'b1;
  end

  // R1
  standby_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    !operate |=> !boostEn);

  // R2
  up_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (boostEn && stat.corrUp) |-> boostLvl);

  // R3
  down_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (boostEn && !stat.corrUp) |-> !boostLvl);

  // R4
  window_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(fvIn) && !fvIn && operate && $past(operate)) |=> stat.winActive);

  // R5
  fit_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stat.fitEvt && operate) |=> !boostEn);

  // R7
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopSeen && operate) |-> !boostEn);

  // R9
  idle_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stat.corrActive |-> !boostEn);
endmodule

bind lock_boost_window lbw_checker uChk (
  .clk      (clk),
  .rstN     (rstN),
  .operate  (operate),
  .fvIn     (fvIn),
  .boostEn  (boostEn),
  .boostLvl (boostLvl),
  .stat     (dpStat)
);

// File: tb/sim_lock_boost_window.sv
module sim_lock_boost_window;
  localparam int N  = 9000;
  localparam int HW = 31;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic operate = 1'b0;
  logic fvIn = 1'b0;
  logic upIn = 1'b0;
  logic dnIn = 1'b0;
  logic boostEn;
  logic boostLvl;

  always #4 clk = ~clk;

  lock_boost_window #(.HALF_WIN(HW)) u0 (
    .clk(clk), .rstN(rstN), .operate(operate), .fvIn(fvIn),
    .upIn(upIn), .dnIn(dnIn), .boostEn(boostEn), .boostLvl(boostLvl)
  );

  bit    opA[N];
  bit    fvA[N];
  bit    upA[N];
  bit    dnA[N];
  bit    eEn[N];
  bit    eLvl[N];
  bit    eDone[N];
  string tagA[N];
  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;

  task automatic chk(string req, int cyc, bit actEn, bit expEn, bit actLvl, bit expLvl);
    checks++;
    if (actEn !== expEn || actLvl !== expLvl) begin
      errors++;
      $display("FAIL %s cycle %0d: en/lvl actual %b/%b expected %b/%b",
               req, cyc, actEn, actLvl, expEn, expLvl);
    end
  endtask

  task automatic fallAt(int at);
    for (int k = at - 20; k < at; k++) if (k >= 0) fvA[k] = 1'b1;
    if (at < N) fvA[at] = 1'b0;
  endtask

  task automatic pulse(int st, int len, bit isUp, string tag);
    for (int k = st; k < st + len && k < N; k++) begin
      if (isUp) upA[k] = 1'b1;
      else      dnA[k] = 1'b1;
    end
    if (tag != "")
      for (int k = st + HW; k <= st + HW + len + 1 && k < N; k++) tagA[k] = tag;
  endtask

  task automatic opLow(int st, int len, string tag);
    for (int k = st; k < st + len && k < N; k++) opA[k] = 1'b0;
    if (tag != "")
      for (int k = st; k < st + len + 3 && k < N; k++) tagA[k] = tag;
  endtask

  // expected output for the state after clock edge c, built from the requirements
  task automatic buildExpected();
    int lastLow = -1;
    int mst = 0;               // 0 standby, 1 boosting, 2 stopped
    bit sCur = 0, sWin = 0, sPrev = 0, sOk = 0, sFit = 0;
    for (int c = 0; c < N; c++) begin
      bit nPrev, nOk, upd, dnd, cur, win, fit;
      int i;
      if (!opA[c]) begin
        lastLow = c; mst = 0; nPrev = 0; nOk = 0;
      end else begin
        if (mst == 0) mst = 1;
        else if (mst == 1 && sFit) mst = 2;
        nPrev = sCur;
        if (sCur && !sPrev) nOk = sWin;
        else if (sCur)      nOk = sOk & sWin;
        else                nOk = sOk;
      end
      i = c - HW;
      upd = (i >= 0 && i > lastLow) ? upA[i] : 1'b0;
      dnd = (i >= 0 && i > lastLow) ? dnA[i] : 1'b0;
      cur = upd | dnd;
      win = 1'b0;
      for (int f = c - 2 * HW + 1; f <= c; f++)
        if (f >= 1 && f - 1 > lastLow && fvA[f - 1] && !fvA[f]) win = 1'b1;
      fit = !cur && nPrev && nOk;
      eEn[c]   = (mst == 1) && cur;
      eLvl[c]  = (mst == 1) && upd;
      eDone[c] = (mst == 2);
      sCur = cur; sWin = win; sPrev = nPrev; sOk = nOk; sFit = fit;
    end
  endtask

  function automatic string kindOf(int c);
    if (tagA[c] != "") return tagA[c];
    if (!opA[c])       return "R1";
    if (eDone[c])      return "R7";
    if (eEn[c] && eLvl[c]) return "R2";
    if (eEn[c])        return "R3";
    return "R9";
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired after %0d checks", checks);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1bd5));
    for (int c = 0; c < N; c++) begin
      opA[c] = (c >= 2); fvA[c] = 0; upA[c] = 0; dnA[c] = 0; tagA[c] = "";
    end
    // directed corner cases
    pulse(100, 10, 1'b1, "R2");
    pulse(200, 8, 1'b0, "R3");
    fallAt(400); pulse(420, 20, 1'b1, "R6");   // runs past window end
    fallAt(600); pulse(560, 20, 1'b0, "R6");   // starts before window
    fallAt(800); pulse(769, 62, 1'b1, "R5");   // fills the whole window
    pulse(1000, 10, 1'b1, "R7");
    fallAt(1200); pulse(1190, 5, 1'b0, "R7");
    opLow(1400, 10, "R1");
    pulse(1500, 6, 1'b1, "R8");
    fallAt(1700); pulse(1668, 5, 1'b1, "R4");  // one sample before window
    pulse(1800, 3, 1'b0, "R4");
    fallAt(1900); pulse(1926, 5, 1'b1, "R4");  // ends on last window sample
    pulse(2000, 4, 1'b1, "R7");
    // random blocks, each entered through a short standby
    for (int b = 2100; b + 700 < N; b += 700) begin
      opLow(b, 4, "");
      for (int k = 0; k < 4; k++) fallAt(b + 50 + int'($urandom % 600));
      for (int k = 0; k < 6; k++)
        pulse(b + 20 + int'($urandom % 620), 1 + int'($urandom % 60), 1'($urandom % 2), "");
    end
    buildExpected();

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", -1, boostEn, 1'b0, boostLvl, 1'b0);
    rstN = 1'b1;
    for (int c = 0; c < N; c++) begin
      operate = opA[c]; fvIn = fvA[c]; upIn = upA[c]; dnIn = dnA[c];
      @(posedge clk);
      #1;
      chk(kindOf(c), c, boostEn, eEn[c], boostLvl, eLvl[c]);
      @(negedge clk);
    end
    finished = 1;
    summary();
    $finish;
  end
endmodule